// File: doc/BRIEF.md
# Configuration Strap Latch Controller

This block captures the chip's configuration straps while the power-on or external pin reset is held, and then holds them. Straps come in two classes. Hard straps are frozen from the moment reset is released. Soft straps act as defaults: a loader that reads non-volatile memory may replace them bit by bit. Some soft straps have a pin. Others take a constant tie-off value that is fixed by a parameter.

The block keeps two separate copies of the soft straps. One is the captured copy, and only the power-on/pin reset writes it. The other is the effective copy that the rest of the chip uses. A digital reset or a reload request copies the captured copy back into the effective copy, so the defaults return without the pins being sampled again. Every strap pin passes through a two-flop synchronizer before it is captured.

Top module: `strap_latch_ctrl`

## Requirements
- R1: Each strap pin passes through two synchronizer flops before capture. A pin value that is present at three or more rising edges before the reset is released is the one captured. A pin change made within the last two rising edges before release is not captured.
- R2: On release of `por_rst`, `hard_strap` equals the synchronized hard pin values.
- R3: After release, `hard_strap` does not change. Pin activity, loader writes, `dig_rst` and `reload_req` have no effect on it.
- R4: On release, `soft_strap[SOFT_PIN_W-1:0]` equals the synchronized soft pins. The upper `SOFT_TIE_W` bits equal the parameter `SOFT_TIE_VAL`, which defaults to 2'b10.
- R5: A cycle with `ldr_valid` high and no restore request sets `soft_strap` to `(old & ~ldr_mask) | (ldr_data & ldr_mask)` after the next rising edge.
- R6: A loader write with an all-zero `ldr_mask` leaves `soft_strap` unchanged.
- R7: A `dig_rst` pulse sets `soft_strap` back to the values captured at the last reset release.
- R8: A `reload_req` pulse sets `soft_strap` back to the captured values, in the same way as R7.
- R9: Restores do not sample the pins again. Pin changes made after release do not appear in `soft_strap` after a restore.
- R10: When a restore and a loader write arrive in the same cycle, the restore takes effect and the write is dropped. A loader write in a later cycle applies on top of the restored values.
- R11: While `por_rst` is high, loader writes are ignored. Each new reset release captures the pins again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on / pin reset, active high, synchronous; straps are captured while it is high |
| dig_rst | input | 1 | Digital reset pulse; restores the soft straps |
| reload_req | input | 1 | Reload command pulse; restores the soft straps |
| hard_pins | input | HARD_W | Hard strap pins |
| soft_pins | input | SOFT_PIN_W | Soft strap pins |
| ldr_valid | input | 1 | Loader override valid |
| ldr_mask | input | SOFT_PIN_W+SOFT_TIE_W | Per-bit override enable |
| ldr_data | input | SOFT_PIN_W+SOFT_TIE_W | Override values |
| hard_strap | output | HARD_W | Effective hard straps |
| soft_strap | output | SOFT_PIN_W+SOFT_TIE_W | Effective soft straps |

## Verification
The bench captures every hard pin pattern and a complementary soft pattern through repeated reset cycles. It then walks every loader mask with varied data, checking each result against a merge computed in the bench. A design that captured the raw pins would catch a pin change made just before release, and the synchronizer-latency check would report it. A design that sampled the pins again on restore would return the new pin levels instead of the captured ones. Giving the loader priority over a simultaneous restore would leave the override data in place. Letting the tie-off bits follow a pin, or letting hard straps follow the loader, would show up in the per-pattern comparisons.

// File: rtl/strap_pkg.sv
package strap_pkg;

    typedef enum logic [1:0] {
        SA_HOLD     = 2'd0,
        SA_CAPTURE  = 2'd1,
        SA_RESTORE  = 2'd2,
        SA_OVERRIDE = 2'd3
    } soft_act_e;

    typedef struct packed {
        logic capture;
        logic restore;
        logic load;
    } strap_req_t;

    // Priority: capture over restore over loader write.
    function automatic soft_act_e pick_action(strap_req_t req);
        if (req.capture)      return SA_CAPTURE;
        else if (req.restore) return SA_RESTORE;
        else if (req.load)    return SA_OVERRIDE;
        else                  return SA_HOLD;
    endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    // Deliberately not reset: the chain must keep sampling while reset is held.
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk) begin
            meta_q <= d_in[i];
            stab_q <= meta_q;
        end
        assign d_out[i] = stab_q;
    end
endmodule

// File: rtl/strap_capture.sv
module strap_capture #(
    parameter int                  HARD_W       = 4,
    parameter int                  SOFT_PIN_W   = 4,
    parameter int                  SOFT_TIE_W   = 2,
    parameter logic [SOFT_TIE_W-1:0] SOFT_TIE_VAL = '0,
    localparam int                 SOFT_W       = SOFT_PIN_W + SOFT_TIE_W
) (
    input  logic                  clk,
    input  logic                  por_rst,
    input  logic [HARD_W-1:0]     hard_sync,
    input  logic [SOFT_PIN_W-1:0] soft_sync,
    output logic [SOFT_W-1:0]     soft_next,
    output logic [HARD_W-1:0]     hard_lat,
    output logic [SOFT_W-1:0]     soft_lat
);
    assign soft_next = {SOFT_TIE_VAL, soft_sync};

    // Only the power-on/pin reset writes these; they freeze on release.
    always_ff @(posedge clk) begin
        if (por_rst) begin
            hard_lat <= hard_sync;
            soft_lat <= soft_next;
        end
    end

    AST_HARD_FROZEN: assert property (@(posedge clk) disable iff (por_rst)
        !por_rst |=> $stable(hard_lat)); // R3
    AST_SOFT_LAT_FROZEN: assert property (@(posedge clk) disable iff (por_rst)
        !por_rst |=> $stable(soft_lat)); // R9
    AST_TIE_HELD: assert property (@(posedge clk) disable iff (por_rst)
        !por_rst |-> soft_lat[SOFT_W-1:SOFT_PIN_W] == SOFT_TIE_VAL); // R4
endmodule

// File: rtl/strap_soft_reg.sv
module strap_soft_reg
    import strap_pkg::*;
#(
    parameter int SOFT_W = 6
) (
    input  logic              clk,
    input  logic              por_rst,
    input  soft_act_e         act,
    input  logic [SOFT_W-1:0] cap_val,
    input  logic [SOFT_W-1:0] lat_val,
    input  logic [SOFT_W-1:0] ov_mask,
    input  logic [SOFT_W-1:0] ov_data,
    output logic [SOFT_W-1:0] eff
);
    logic [SOFT_W-1:0] eff_d;

    always_comb begin
        unique case (act)
            SA_CAPTURE:  eff_d = cap_val;
            SA_RESTORE:  eff_d = lat_val;
            SA_OVERRIDE: eff_d = (eff & ~ov_mask) | (ov_data & ov_mask);
            default:     eff_d = eff;
        endcase
    end

    always_ff @(posedge clk) begin
        eff <= eff_d;
    end

    AST_RESTORE_COPIES: assert property (@(posedge clk) disable iff (por_rst)
        act == SA_RESTORE |=> eff == $past(lat_val)); // R7
    AST_OVERRIDE_BITS: assert property (@(posedge clk) disable iff (por_rst)
        act == SA_OVERRIDE |=> ((eff ^ $past(ov_data)) & $past(ov_mask)) == '0); // R5
    AST_OVERRIDE_KEEP: assert property (@(posedge clk) disable iff (por_rst)
        act == SA_OVERRIDE |=> ((eff ^ $past(eff)) & ~$past(ov_mask)) == '0); // R5
    AST_ZERO_MASK: assert property (@(posedge clk) disable iff (por_rst)
        (act == SA_OVERRIDE && ov_mask == '0) |=> $stable(eff)); // R6
endmodule

// File: rtl/strap_latch_ctrl.sv
module strap_latch_ctrl
    import strap_pkg::*;
#(
    parameter int                    HARD_W       = 4,
    parameter int                    SOFT_PIN_W   = 4,
    parameter int                    SOFT_TIE_W   = 2,
    parameter logic [SOFT_TIE_W-1:0] SOFT_TIE_VAL = 2'b10
) (
    input  logic                             clk,
    input  logic                             por_rst,
    input  logic                             dig_rst,
    input  logic                             reload_req,
    input  logic [HARD_W-1:0]                hard_pins,
    input  logic [SOFT_PIN_W-1:0]            soft_pins,
    input  logic                             ldr_valid,
    input  logic [SOFT_PIN_W+SOFT_TIE_W-1:0] ldr_mask,
    input  logic [SOFT_PIN_W+SOFT_TIE_W-1:0] ldr_data,
    output logic [HARD_W-1:0]                hard_strap,
    output logic [SOFT_PIN_W+SOFT_TIE_W-1:0] soft_strap
);
    localparam int SOFT_W = SOFT_PIN_W + SOFT_TIE_W;
    localparam int PIN_W  = HARD_W + SOFT_PIN_W;

    logic [PIN_W-1:0]      pins_sync;
    logic [SOFT_W-1:0]     soft_next;
    logic [SOFT_W-1:0]     soft_lat;
    strap_req_t            req;
    soft_act_e             act;

    strap_sync #(.W(PIN_W)) u_sync (
        .clk   (clk),
        .d_in  ({hard_pins, soft_pins}),
        .d_out (pins_sync)
    );

    strap_capture #(
        .HARD_W       (HARD_W),
        .SOFT_PIN_W   (SOFT_PIN_W),
        .SOFT_TIE_W   (SOFT_TIE_W),
        .SOFT_TIE_VAL (SOFT_TIE_VAL)
    ) u_capture (
        .clk       (clk),
        .por_rst   (por_rst),
        .hard_sync (pins_sync[PIN_W-1:SOFT_PIN_W]),
        .soft_sync (pins_sync[SOFT_PIN_W-1:0]),
        .soft_next (soft_next),
        .hard_lat  (hard_strap),
        .soft_lat  (soft_lat)
    );

    always_comb begin
        req.capture = por_rst;
        req.restore = dig_rst | reload_req;
        req.load    = ldr_valid;
        act         = pick_action(req);
    end

    strap_soft_reg #(.SOFT_W(SOFT_W)) u_soft (
        .clk     (clk),
        .por_rst (por_rst),
        .act     (act),
        .cap_val (soft_next),
        .lat_val (soft_lat),
        .ov_mask (ldr_mask),
        .ov_data (ldr_data),
        .eff     (soft_strap)
    );

    AST_RESTORE_WINS: assert property (@(posedge clk) disable iff (por_rst)
        ((dig_rst || reload_req) && ldr_valid) |=> soft_strap == $past(soft_lat)); // R10
    AST_RELOAD_RESTORES: assert property (@(posedge clk) disable iff (por_rst)
        reload_req |=> soft_strap == $past(soft_lat)); // R8
endmodule

// File: tb/strap_latch_ctrl_tb_top.sv
module strap_latch_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       por_rst = 1'b1;
    logic       dig_rst = 1'b0;
    logic       reload_req = 1'b0;
    logic [3:0] hard_pins = '0;
    logic [3:0] soft_pins = '0;
    logic       ldr_valid = 1'b0;
    logic [5:0] ldr_mask = '0;
    logic [5:0] ldr_data = '0;
    logic [3:0] hard_strap;
    logic [5:0] soft_strap;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;
    localparam logic [1:0] TIE = 2'b10;

    always #4 clk = ~clk;  // 125 MHz

    strap_latch_ctrl dut_i (
        .clk(clk), .por_rst(por_rst), .dig_rst(dig_rst), .reload_req(reload_req),
        .hard_pins(hard_pins), .soft_pins(soft_pins), .ldr_valid(ldr_valid),
        .ldr_mask(ldr_mask), .ldr_data(ldr_data),
        .hard_strap(hard_strap), .soft_strap(soft_strap)
    );

    task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic por_capture(input logic [3:0] h, input logic [3:0] s);
        @(negedge clk);
        por_rst = 1'b1; hard_pins = h; soft_pins = s;
        repeat (4) @(negedge clk);
        por_rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic load(input logic [5:0] m, input logic [5:0] d);
        ldr_valid = 1'b1; ldr_mask = m; ldr_data = d;
        @(negedge clk);
        ldr_valid = 1'b0;
    endtask

    initial begin
        logic [5:0] model;
        logic [5:0] lat;
        // reset state after first release
        por_capture(4'h0, 4'h0);
        chk("R2 reset hard", {2'b00, hard_strap}, 6'h00);
        chk("R4 reset soft", soft_strap, {TIE, 4'h0});

        // sweep of all hard patterns with complementary soft pins
        for (int v = 0; v < 16; v++) begin
            por_capture(v[3:0], ~v[3:0]);
            chk("R2 hard capture", {2'b00, hard_strap}, {2'b00, v[3:0]});
            chk("R4 soft capture", soft_strap, {TIE, ~v[3:0]});
        end
        lat = {TIE, 4'h0};

        // R1: pin change within last two edges before release is not captured
        @(negedge clk);
        por_rst = 1'b1; hard_pins = 4'h9; soft_pins = 4'h6;
        repeat (4) @(negedge clk);
        hard_pins = 4'h3; soft_pins = 4'hC;
        repeat (2) @(negedge clk);
        por_rst = 1'b0;
        @(negedge clk);
        chk("R1 late hard change", {2'b00, hard_strap}, 6'h09);
        chk("R1 late soft change", soft_strap, {TIE, 4'h6});
        lat = {TIE, 4'h6};

        // pins change after release: no effect
        hard_pins = 4'hF; soft_pins = 4'h0;
        repeat (4) @(negedge clk);
        chk("R3 hard ignores pins", {2'b00, hard_strap}, 6'h09);
        chk("R9 soft ignores pins", soft_strap, lat);

        // loader sweep over every mask
        model = lat;
        for (int m = 0; m < 64; m++) begin
            logic [5:0] d;
            d = 6'((m * 37 + 11) & 63);
            load(m[5:0], d);
            model = (model & ~m[5:0]) | (d & m[5:0]);
            if (m == 0) chk("R6 zero mask", soft_strap, model);
            else        chk("R5 override", soft_strap, model);
        end
        chk("R3 hard ignores loader", {2'b00, hard_strap}, 6'h09);

        // digital reset restores latched copy, pins not resampled
        dig_rst = 1'b1; @(negedge clk); dig_rst = 1'b0;
        chk("R7 dig_rst restore", soft_strap, lat);
        chk("R9 no resample", soft_strap, lat);
        chk("R3 hard after dig_rst", {2'b00, hard_strap}, 6'h09);

        load(6'h3F, 6'h2A);
        chk("R5 full override", soft_strap, 6'h2A);
        reload_req = 1'b1; @(negedge clk); reload_req = 1'b0;
        chk("R8 reload restore", soft_strap, lat);
        chk("R3 hard after reload", {2'b00, hard_strap}, 6'h09);

        // restore and loader in the same cycle
        load(6'h3F, 6'h01);
        dig_rst = 1'b1; ldr_valid = 1'b1; ldr_mask = 6'h3F; ldr_data = 6'h15;
        @(negedge clk);
        dig_rst = 1'b0; ldr_valid = 1'b0;
        chk("R10 restore wins", soft_strap, lat);
        load(6'h0F, 6'h15);
        chk("R10 later load applies", soft_strap, (lat & ~6'h0F) | (6'h15 & 6'h0F));

        // loader ignored during reset, new capture
        @(negedge clk);
        por_rst = 1'b1; hard_pins = 4'hA; soft_pins = 4'h3;
        repeat (4) @(negedge clk);
        load(6'h3F, 6'h3C);
        @(negedge clk);
        por_rst = 1'b0;
        @(negedge clk);
        chk("R11 loader ignored in reset", soft_strap, {TIE, 4'h3});
        chk("R11 new hard capture", {2'b00, hard_strap}, 6'h0A);
        reload_req = 1'b1; @(negedge clk); reload_req = 1'b0;
        chk("R11 reload after recapture", soft_strap, {TIE, 4'h3});

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule